// File: doc/BRIEF.md
# Shadow-Backed SRAM Store/Recall Controller

This block is a synchronous model of a static RAM in which every word has a nonvolatile shadow copy. A host reads and writes the array through active-low chip, output and write enables, with one active-low enable for each byte lane. The whole array can be copied to the shadow (store) or back from it (recall) in one bulk transfer. While a transfer runs, a busy output is raised for a fixed number of cycles and all host access is locked out.

A transfer can be started by four triggers: leaving reset (treated as power-up), a power-fail input, an active-low hardware store strobe and software command pulses. A dirty flag records whether any write has completed since the last transfer. Power-fail and strobe stores are skipped when that flag is clear. Software stores always run.

Top module: `sram_shadow_ctl`

## Requirements
- R1: A read drives `rdata` and raises `rd_oe` only when `ce_n` and `oe_n` are low, `we_n`, `sleep_n` and `hs_n` are high, and no transfer is busy or pending. Otherwise `rdata` is zero. Read data follows `addr` combinationally.
- R2: A write happens at the clock edge when `ce_n` and `we_n` are low and `hs_n` is high. `be_n[i]` low enables lane i, which is bits 8i+7..8i. Disabled lanes keep their old contents.
- R3: During a read, lanes whose `be_n` bit is high return zero.
- R4: While `busy` is high, reads are not driven and writes are dropped. A write in the same cycle as a trigger that starts a transfer is also dropped.
- R5: After reset is released, a recall starts at the first clock edge. Until that recall completes, no access is allowed.
- R6: `busy` rises at the clock edge that accepts a trigger and stays high for exactly LAT cycles.
- R7: The dirty flag is set by each completed write and cleared when any store or recall starts.
- R8: A power-fail store (`pwr_fail` high) or a strobe store (`hs_n` low) starts only when the dirty flag is set.
- R9: A `sw_store` pulse starts a store even when the dirty flag is clear. A `sw_recall` pulse overwrites the array with the shadow contents.
- R10: With `auto_en` low, `pwr_fail` starts no store.
- R11: Triggers that arrive while `busy` is high are dropped, not queued.
- R12: When several triggers arrive in the same cycle, the order is: power-up recall, then power-fail store, then strobe store, then software store, then software recall.
- R13: Shadow contents survive reset and are restored into the array by the power-up recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release acts as power-up |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| sleep_n | input | 1 | Sleep control; low blocks reads |
| hs_n | input | 1 | Hardware store strobe, active low; low blocks access |
| be_n | input | LANES | Byte-lane enables, active low |
| addr | input | AW | Word address |
| wdata | input | 8*LANES | Write data |
| rdata | output | 8*LANES | Read data, zero when not driven |
| rd_oe | output | 1 | High when `rdata` is driven |
| pwr_fail | input | 1 | Supply-fail indication |
| auto_en | input | 1 | Enables the power-fail store |
| sw_store | input | 1 | Software store command pulse |
| sw_recall | input | 1 | Software recall command pulse |
| busy | output | 1 | Transfer in progress |

## Verification
Each trigger is tried both with the dirty flag clear and with it set. The clean cases separate the conditional stores (power-fail and strobe), which must not raise `busy`, from the software store, which must. Recall is seen through changed read data: a word overwritten after a store reads back its stored value once the recall has run. The same word read again after a reset shows that the shadow survives reset. Triggers that arrive together pair a store with a recall on a freshly written word, so the read-back shows which one won. A write attempted during `busy` is tested against a later clean power-fail that must not start a store, which shows that the write neither landed nor set the dirty flag.

// File: rtl/sram_shadow_ctl.sv
module sram_shadow_ctl #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int LAT   = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int W  = 8 * LANES,
  localparam int CW = $clog2(LAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             sleep_n,
  input  logic             hs_n,
  input  logic [LANES-1:0] be_n,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic             rd_oe,
  input  logic             pwr_fail,
  input  logic             auto_en,
  input  logic             sw_store,
  input  logic             sw_recall,
  output logic             busy
);

  logic [W-1:0]  mem    [DEPTH];
  logic [W-1:0]  shadow [DEPTH] = '{default: '0};
  logic [CW-1:0] cnt;
  logic          dirty, pu_pend;
  logic [W-1:0]  lmask;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lmask[8*i +: 8] = {8{~be_n[i]}};
  end

  wire ok      = !busy && !pu_pend;
  wire rd_cond = !ce_n && !oe_n && we_n && sleep_n && hs_n;
  wire wr_cond = !ce_n && !we_n && hs_n;

  wire pf_go    = pwr_fail && auto_en && dirty;
  wire hw_go    = !hs_n && dirty;
  wire start_st = ok && (pf_go || hw_go || sw_store);
  wire start_rc = !busy && (pu_pend || (!pf_go && !hw_go && !sw_store && sw_recall));
  wire start    = start_st || start_rc;
  wire wr_go    = wr_cond && ok && !start;

  assign rd_oe = rd_cond && ok;
  assign rdata = rd_oe ? (mem[addr] & lmask) : '0;

  always_ff @(posedge clk) begin
    if (start_st) begin
      for (int i = 0; i < DEPTH; i++) shadow[i] <= mem[i];
    end else if (start_rc) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= shadow[i];
    end else if (wr_go) begin
      mem[addr] <= (mem[addr] & ~lmask) | (wdata & lmask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      dirty   <= 1'b0;
      pu_pend <= 1'b1;
    end else begin
      if (start) begin
        busy    <= 1'b1;
        cnt     <= CW'(LAT - 1);
        pu_pend <= 1'b0;
        dirty   <= 1'b0;
      end else begin
        if (busy) begin
          if (cnt == '0) busy <= 1'b0;
          else           cnt  <= cnt - 1'b1;
        end
        if (wr_go) dirty <= 1'b1;
      end
    end
  end

endmodule

module sram_shadow_chk #(
  parameter int LAT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic rd_oe,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic sleep_n,
  input logic hs_n,
  input logic dirty,
  input logic pu_pend,
  input logic sw_store,
  input logic sw_recall,
  input logic rdata_nz
);

  int n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    n <= 0;
    else if (busy) n <= n + 1;
    else           n <= 0;
  end

  // R1
  rd_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (!ce_n && !oe_n && we_n && sleep_n && hs_n));

  // R1
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> !rdata_nz);

  // R4
  no_rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_oe);

  // R5
  pu_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_pend && !busy) |=> busy);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (n == LAT));

  // R6
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (n < LAT));

  // R7
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !dirty);

  // R8
  clean_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pu_pend && !dirty && !sw_store && !sw_recall) |=> !busy);

endmodule

bind sram_shadow_ctl sram_shadow_chk #(.LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_oe(rd_oe),
  .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .sleep_n(sleep_n), .hs_n(hs_n),
  .dirty(dirty), .pu_pend(pu_pend), .sw_store(sw_store), .sw_recall(sw_recall),
  .rdata_nz(|rdata)
);

// File: tb/tb_sram_shadow_ctl.sv
module tb_sram_shadow_ctl;
  localparam int LAT = 8;

  logic        clk = 0, rst_n = 0;
  logic        ce_n, oe_n, we_n, sleep_n, hs_n, pwr_fail, auto_en, sw_store, sw_recall;
  logic [3:0]  be_n, addr;
  logic [31:0] wdata, rdata;
  logic        rd_oe, busy;

  int checks = 0, fails = 0;

  typedef struct {
    logic [31:0] rd;
    logic        oe;
    logic        bz;
    string       tag;
  } item_t;
  item_t q[$];

  sram_shadow_ctl #(.DEPTH(16), .LANES(4), .LAT(LAT)) dut (.*);

  always #5 clk = ~clk;

  function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(rdata == it.rd && rd_oe == it.oe && busy == it.bz, it.tag,
          {rdata[29:0], rd_oe, busy}, {it.rd[29:0], it.oe, it.bz});
    end
  end

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1; sleep_n = 1; hs_n = 1;
    pwr_fail = 0; sw_store = 0; sw_recall = 0; be_n = 4'h0; addr = 0; wdata = 0;
  endtask

  task automatic expect_now(logic [31:0] rd, logic oe, logic bz, string tag);
    item_t it;
    it.rd = rd; it.oe = oe; it.bz = bz; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] b);
    @(posedge clk); #1; idle();
    ce_n = 0; we_n = 0; addr = a; wdata = d; be_n = b;
  endtask

  task automatic rd(logic [3:0] a, logic [3:0] b, logic [31:0] exp, string tag);
    @(posedge clk); #1; idle();
    ce_n = 0; oe_n = 0; addr = a; be_n = b;
    expect_now(exp, 1'b1, 1'b0, tag);
  endtask

  task automatic trig(bit pf, bit hs, bit st, bit rc);
    @(posedge clk); #1; idle();
    pwr_fail = pf; hs_n = !hs; sw_store = st; sw_recall = rc;
  endtask

  task automatic no_start(string tag);
    @(posedge clk); #1; idle();
    expect_now(32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic wait_busy(string tag);
    int n = 0;
    @(posedge clk); #1; idle();
    @(negedge clk);
    while (busy && n < 4 * LAT) begin
      n++;
      @(negedge clk);
    end
    chk(n == LAT, tag, n, LAT);
  endtask

  initial begin
    idle(); auto_en = 1;
    // reset state
    expect_now(32'h0, 1'b0, 1'b0, "reset state");
    @(posedge clk); #1; rst_n = 1;
    // R5: recall after reset, access blocked; R6 length
    @(posedge clk); #1; idle();
    ce_n = 0; oe_n = 0; addr = 3;
    expect_now(32'h0, 1'b0, 1'b1, "R5 recall blocks read");
    begin
      int n = 1;
      @(negedge clk);
      @(negedge clk);
      while (busy && n < 4 * LAT) begin n++; @(negedge clk); end
      chk(n == LAT, "R6 power-up busy length", n, LAT);
    end
    rd(3, 4'h0, 32'h0, "R5 recalled zero");
    // R2 write, full and lane-masked
    wr(3, 32'hA1B2C3D4, 4'h0);
    rd(3, 4'h0, 32'hA1B2C3D4, "R2 full write");
    wr(3, 32'h11223344, 4'b1010);
    rd(3, 4'h0, 32'hA122C344, "R2 lane write");
    // R3 read lanes
    rd(3, 4'b0011, 32'hA1220000, "R3 read lanes");
    // R1 sleep blocks read
    @(posedge clk); #1; idle();
    ce_n = 0; oe_n = 0; sleep_n = 0; addr = 3;
    expect_now(32'h0, 1'b0, 1'b0, "R1 sleep blocks read");
    // R1 oe_n high blocks read
    @(posedge clk); #1; idle();
    ce_n = 0; addr = 3;
    expect_now(32'h0, 1'b0, 1'b0, "R1 oe_n high");
    // R8 strobe store while dirty
    trig(0, 1, 0, 0);
    wait_busy("R6 R8 dirty strobe store");
    // R7 R8 clean strobe and power-fail skipped
    trig(0, 1, 0, 0);
    no_start("R7 R8 clean strobe skipped");
    trig(1, 0, 0, 0);
    no_start("R8 clean power-fail skipped");
    // R9 software store when clean
    trig(0, 0, 1, 0);
    wait_busy("R9 clean sw store runs");
    // R9 recall restores stored word
    wr(3, 32'hDEADBEEF, 4'h0);
    rd(3, 4'h0, 32'hDEADBEEF, "R2 overwrite");
    trig(0, 0, 0, 1);
    wait_busy("R9 sw recall busy");
    rd(3, 4'h0, 32'hA122C344, "R9 recall restores");
    trig(1, 0, 0, 0);
    no_start("R7 recall clears latch");
    // R10 auto disable
    auto_en = 0;
    wr(4, 32'h44440000, 4'h0);
    trig(1, 0, 0, 0);
    no_start("R10 auto disabled");
    auto_en = 1;
    trig(1, 0, 0, 0);
    wait_busy("R10 R8 power-fail store");
    // R4 R11 access and triggers during busy
    trig(0, 0, 1, 0);
    @(posedge clk); #1; idle();
    ce_n = 0; we_n = 0; addr = 7; wdata = 32'h77777777; sw_recall = 1;
    repeat (3) @(posedge clk);
    #1; idle();
    ce_n = 0; oe_n = 0; addr = 4;
    expect_now(32'h0, 1'b0, 1'b1, "R4 read blocked while busy");
    begin
      int g = 0;
      @(negedge clk);
      while (busy && g < 4 * LAT) begin g++; @(negedge clk); end
    end
    no_start("R11 dropped trigger");
    rd(7, 4'h0, 32'h0, "R4 write dropped");
    trig(1, 0, 0, 0);
    no_start("R4 R7 blocked write left latch clear");
    // R12 priority: power-fail store over sw recall
    wr(2, 32'h22222222, 4'h0);
    trig(1, 0, 0, 1);
    wait_busy("R12 pf vs recall busy");
    rd(2, 4'h0, 32'h22222222, "R12 store won over recall");
    // R12 strobe store over sw recall
    wr(5, 32'h55555555, 4'h0);
    trig(0, 1, 0, 1);
    wait_busy("R12 strobe vs recall busy");
    rd(5, 4'h0, 32'h55555555, "R12 strobe won over recall");
    // R13 shadow survives reset
    wr(2, 32'h0BADF00D, 4'h0);
    @(posedge clk); #1; idle(); rst_n = 0;
    @(posedge clk); #1; rst_n = 1;
    wait_busy("R5 R6 second power-up");
    rd(2, 4'h0, 32'h22222222, "R13 shadow kept word 2");
    rd(4, 4'h0, 32'h44440000, "R13 shadow kept word 4");
    rd(3, 4'h0, 32'hA122C344, "R13 shadow kept word 3");
    @(posedge clk); @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule